// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single-beat requests from an internal port into cycles on an external memory bus. The low sixteen address bits and the sixteen data bits share one set of pins. Each external access first drives the address onto the shared pins. An address-latch strobe marks the address so that external logic can capture it. The block then runs a read strobe or a byte-qualified write strobe. A separate strobe covers each byte lane, so 8-bit and 16-bit devices can share the bus. The full address is also driven on a dedicated address output for the whole access.

Four active-low chip selects are decoded from programmable base/mask windows. When windows overlap, the lowest-numbered window wins. Each window can turn on a 1+N wait scheme driven by an external active-low wait input. Addresses inside the internal I/O, RAM and ROM ranges complete in one cycle and touch no external strobe. An external master can take the bus through an active-low request/acknowledge pair. While the bus is granted, every bus output is floated.

The controller runs on a clock at twice the bus rate. One clock cycle is one half bus clock, called a phase below.

Top module: `muxbus_ctrl`

## Requirements
- R1: After reset, ale_o=0, rd_n=wr_n=hwr_n=1, rw_o=1, cs_n=all ones, busak_n=1, bus_drive=1 and ad_oe=0.
- R2: An external access holds ale_o high for exactly two phases, starting the cycle after acceptance. During those phases ad_o equals the address bits 15:0, addr_o equals the full address and ad_oe=1. ale_o is then low for one phase, and the strobe falls in the phase after that (the fourth phase after acceptance).
- R3: A read holds rd_n low for 4 phases when no wait is inserted, with rw_o=1 and ad_oe=0. The value on ad_i in the last low phase is returned on rsp_rdata. rsp_valid pulses for one cycle in the phase after rd_n rises.
- R4: A write keeps rw_o=0 and drives ad_o with the write data while strobing. wr_n is low when byte enable bit 0 is set and hwr_n is low when byte enable bit 1 is set, each for 3 phases when no wait is inserted. rsp_valid pulses in the phase after the strobe ends.
- R5: Window i matches when (addr XOR base_i) AND NOT mask_i is zero, where a mask bit of 1 means "don't care". Only the lowest-numbered matching window drives its cs_n bit low, from the first latch-strobe phase through the completion phase. With no match, all cs_n bits stay high.
- R6: When the selected window has its wait enable set, the strobe gains 2 phases unconditionally. wait_n is sampled at the end of each 2-phase wait unit, and each sample that finds it low adds another 2 phases.
- R7: An access in 0x000000–0x000FFF, 0x001000–0x004FFF or 0xFC0000–0xFFFFFF produces no latch strobe, no read/write strobe and no chip select, even when a window matches. rsp_valid pulses in the cycle after acceptance, and read data is 0.
- R8: In an idle cycle with busrq_n=0 and wait_n=1, the next cycle has busak_n=0, bus_drive=0 and ad_oe=0. No request is accepted while the bus is granted.
- R9: A bus request is not granted while wait_n=0. The grant follows one cycle after wait_n returns high.
- R10: A bus request that arrives during an external access is granted only after that access has completed.
- R11: When busrq_n returns high, busak_n rises one phase before bus_drive returns to 1.
- R12: When a new request and a bus request both appear in the same idle cycle, the bus is granted first. The request runs after the bus has been returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock (two per bus clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_be | input | 2 | Byte enables (bit 0 low lane, bit 1 high lane) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Access completed |
| rsp_rdata | output | 16 | Read data |
| cs_base | input | N_CS*ADDR_W | Window base addresses, window i at bits i*ADDR_W |
| cs_mask | input | N_CS*ADDR_W | Window don't-care masks |
| cs_wait_en | input | N_CS | Per-window 1+N wait enable |
| addr_o | output | ADDR_W | Full address output |
| ad_o | output | 16 | Shared address/data output value |
| ad_i | input | 16 | Shared address/data input value |
| ad_oe | output | 1 | Drive enable for the shared pins |
| ale_o | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Low-lane write strobe, active low |
| hwr_n | output | 1 | High-lane write strobe, active low |
| rw_o | output | 1 | 1 for read or idle, 0 for write |
| cs_n | output | N_CS | Chip selects, active low |
| bus_drive | output | 1 | Drive enable for addr_o, strobes, rw_o and cs_n |
| wait_n | input | 1 | External wait, active low |
| busrq_n | input | 1 | External bus request, active low |
| busak_n | output | 1 | Bus acknowledge, active low |

## Verification
Two functions can meet in one idle cycle: starting a new access and granting the bus to an external master. The bench raises req_valid and busrq_n low at the same falling edge. A correct result has busak_n low one cycle later, no latch strobe while the bus is out, and the held request running in full once the bus returns. A second collision comes from dropping busrq_n in the middle of a read that wait_n is stretching. There, acknowledge must stay high until the completion pulse has gone by. A third case holds wait_n low against a pending bus request to show that the grant is held back.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  localparam int DATA_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ALE, ST_ADR, ST_STB, ST_WAIT, ST_HOLD, ST_INT, ST_REL, ST_RET
  } bus_st_t;

  // base/mask window match: mask bit 1 = don't care
  function automatic logic win_hit(input logic [31:0] a, input logic [31:0] base,
                                   input logic [31:0] mask);
    return ((a ^ base) & ~mask) == 32'd0;
  endfunction

  function automatic logic in_span(input logic [31:0] a, input logic [31:0] lo,
                                   input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/muxbus_csdec.sv
module muxbus_csdec import muxbus_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int N_CS   = 4
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [N_CS*ADDR_W-1:0] cs_base,
  input  logic [N_CS*ADDR_W-1:0] cs_mask,
  input  logic [N_CS-1:0]        cs_wait_en,
  output logic [N_CS-1:0]        sel,
  output logic                   sel_wait
);

  logic [N_CS-1:0] raw_hit;

  generate
    for (genvar g = 0; g < N_CS; g++) begin : g_win
      assign raw_hit[g] = win_hit(32'(addr), 32'(cs_base[g*ADDR_W +: ADDR_W]),
                                  32'(cs_mask[g*ADDR_W +: ADDR_W]));
    end
  endgenerate

  // walk from highest to lowest so the lowest index is left standing
  always_comb begin
    sel      = '0;
    sel_wait = 1'b0;
    for (int i = N_CS - 1; i >= 0; i--) begin
      if (raw_hit[i]) begin
        sel      = '0;
        sel[i]   = 1'b1;
        sel_wait = cs_wait_en[i];
      end
    end
  end

endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq import muxbus_pkg::*; #(
  parameter int              ADDR_W = 24,
  parameter int              N_CS   = 4,
  parameter int              RD_PH  = 4,
  parameter int              WR_PH  = 3,
  parameter logic [ADDR_W-1:0] IO_LO  = 'h000000,
  parameter logic [ADDR_W-1:0] IO_HI  = 'h000FFF,
  parameter logic [ADDR_W-1:0] RAM_LO = 'h001000,
  parameter logic [ADDR_W-1:0] RAM_HI = 'h004FFF,
  parameter logic [ADDR_W-1:0] ROM_LO = 'hFC0000,
  parameter logic [ADDR_W-1:0] ROM_HI = 'hFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [N_CS-1:0]   sel,
  input  logic              sel_wait,
  input  logic              wait_n,
  input  logic              busrq_n,
  input  logic [DATA_W-1:0] ad_i,
  output bus_st_t           st,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_write,
  output logic [1:0]        lat_be,
  output logic [DATA_W-1:0] lat_wdata,
  output logic [N_CS-1:0]   lat_cs,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busak_n,
  output logic              accept,
  output logic              int_hit
);

  localparam int MAX_PH = (RD_PH > WR_PH) ? RD_PH : WR_PH;
  localparam int CNT_W  = (MAX_PH > 2) ? $clog2(MAX_PH) : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_ph;
  logic             lat_wen;
  logic             rel_go;

  assign int_hit = in_span(32'(req_addr), 32'(IO_LO), 32'(IO_HI)) ||
                   in_span(32'(req_addr), 32'(RAM_LO), 32'(RAM_HI)) ||
                   in_span(32'(req_addr), 32'(ROM_LO), 32'(ROM_HI));
  assign rel_go    = !busrq_n && wait_n;
  assign req_ready = (st == ST_IDLE) && !rel_go;
  assign accept    = req_valid && req_ready;
  assign rsp_valid = (st == ST_HOLD) || (st == ST_INT);
  assign busak_n   = (st != ST_REL);
  assign last_ph   = lat_write ? CNT_W'(WR_PH - 1) : CNT_W'(RD_PH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      lat_addr  <= '0;
      lat_write <= 1'b0;
      lat_be    <= '0;
      lat_wdata <= '0;
      lat_cs    <= '0;
      lat_wen   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (rel_go) begin
            st <= ST_REL;
          end else if (req_valid) begin
            lat_addr  <= req_addr;
            lat_write <= req_write;
            lat_be    <= req_be;
            lat_wdata <= req_wdata;
            lat_cs    <= int_hit ? '0 : sel;
            lat_wen   <= !int_hit && sel_wait;
            cnt       <= '0;
            st        <= int_hit ? ST_INT : ST_ALE;
            if (int_hit && !req_write) rsp_rdata <= '0;
          end
        end
        ST_ALE: begin
          if (cnt == CNT_W'(1)) begin
            cnt <= '0;
            st  <= ST_ADR;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_ADR: begin
          cnt <= '0;
          st  <= ST_STB;
        end
        ST_STB: begin
          if (cnt == last_ph) begin
            cnt <= '0;
            if (lat_wen) begin
              st <= ST_WAIT;
            end else begin
              st <= ST_HOLD;
              if (!lat_write) rsp_rdata <= ad_i;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WAIT: begin
          if (cnt == CNT_W'(1)) begin
            cnt <= '0;
            if (wait_n) begin
              st <= ST_HOLD;
              if (!lat_write) rsp_rdata <= ad_i;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_HOLD: st <= ST_IDLE;
        ST_INT:  st <= ST_IDLE;
        ST_REL:  if (busrq_n) st <= ST_RET;
        ST_RET:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/muxbus_pins.sv
module muxbus_pins import muxbus_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int N_CS   = 4
) (
  input  bus_st_t           st,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic              lat_write,
  input  logic [1:0]        lat_be,
  input  logic [DATA_W-1:0] lat_wdata,
  input  logic [N_CS-1:0]   lat_cs,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic              ale_o,
  output logic              rd_n,
  output logic              wr_n,
  output logic              hwr_n,
  output logic              rw_o,
  output logic [N_CS-1:0]   cs_n,
  output logic              bus_drive
);

  logic addr_ph;
  logic strobe_ph;
  logic ext_cycle;
  logic released;

  assign addr_ph   = (st == ST_ALE) || (st == ST_ADR);
  assign strobe_ph = (st == ST_STB) || (st == ST_WAIT);
  assign ext_cycle = addr_ph || strobe_ph || (st == ST_HOLD);
  assign released  = (st == ST_REL) || (st == ST_RET);

  assign bus_drive = !released;
  assign addr_o    = lat_addr;
  assign ale_o     = (st == ST_ALE);
  assign ad_o      = addr_ph ? lat_addr[DATA_W-1:0] : lat_wdata;
  assign ad_oe     = !released &&
                     (addr_ph || (lat_write && (strobe_ph || st == ST_HOLD)));
  assign rd_n      = !(strobe_ph && !lat_write);
  assign wr_n      = !(strobe_ph && lat_write && lat_be[0]);
  assign hwr_n     = !(strobe_ph && lat_write && lat_be[1]);
  assign rw_o      = !(ext_cycle && lat_write);
  assign cs_n      = ext_cycle ? ~lat_cs : '1;

endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl import muxbus_pkg::*; #(
  parameter int              ADDR_W = 24,
  parameter int              N_CS   = 4,
  parameter int              RD_PH  = 4,
  parameter int              WR_PH  = 3,
  parameter logic [ADDR_W-1:0] IO_LO  = 'h000000,
  parameter logic [ADDR_W-1:0] IO_HI  = 'h000FFF,
  parameter logic [ADDR_W-1:0] RAM_LO = 'h001000,
  parameter logic [ADDR_W-1:0] RAM_HI = 'h004FFF,
  parameter logic [ADDR_W-1:0] ROM_LO = 'hFC0000,
  parameter logic [ADDR_W-1:0] ROM_HI = 'hFFFFFF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_write,
  input  logic [1:0]             req_be,
  input  logic [15:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [15:0]            rsp_rdata,
  input  logic [N_CS*ADDR_W-1:0] cs_base,
  input  logic [N_CS*ADDR_W-1:0] cs_mask,
  input  logic [N_CS-1:0]        cs_wait_en,
  output logic [ADDR_W-1:0]      addr_o,
  output logic [15:0]            ad_o,
  input  logic [15:0]            ad_i,
  output logic                   ad_oe,
  output logic                   ale_o,
  output logic                   rd_n,
  output logic                   wr_n,
  output logic                   hwr_n,
  output logic                   rw_o,
  output logic [N_CS-1:0]        cs_n,
  output logic                   bus_drive,
  input  logic                   wait_n,
  input  logic                   busrq_n,
  output logic                   busak_n
);

  bus_st_t           st;
  logic [N_CS-1:0]   sel;
  logic              sel_wait;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_write;
  logic [1:0]        lat_be;
  logic [15:0]       lat_wdata;
  logic [N_CS-1:0]   lat_cs;
  logic              accept;
  logic              int_hit;
  logic              int_acc;

  // named event for the checker: an internal-range access accepted
  assign int_acc = accept && int_hit;

  muxbus_csdec #(.ADDR_W(ADDR_W), .N_CS(N_CS)) u_dec (
    .addr(req_addr), .cs_base(cs_base), .cs_mask(cs_mask),
    .cs_wait_en(cs_wait_en), .sel(sel), .sel_wait(sel_wait)
  );

  muxbus_seq #(
    .ADDR_W(ADDR_W), .N_CS(N_CS), .RD_PH(RD_PH), .WR_PH(WR_PH),
    .IO_LO(IO_LO), .IO_HI(IO_HI), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI),
    .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .sel(sel), .sel_wait(sel_wait), .wait_n(wait_n), .busrq_n(busrq_n),
    .ad_i(ad_i), .st(st), .lat_addr(lat_addr), .lat_write(lat_write),
    .lat_be(lat_be), .lat_wdata(lat_wdata), .lat_cs(lat_cs),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .busak_n(busak_n), .accept(accept), .int_hit(int_hit)
  );

  muxbus_pins #(.ADDR_W(ADDR_W), .N_CS(N_CS)) u_pins (
    .st(st), .lat_addr(lat_addr), .lat_write(lat_write), .lat_be(lat_be),
    .lat_wdata(lat_wdata), .lat_cs(lat_cs), .addr_o(addr_o), .ad_o(ad_o),
    .ad_oe(ad_oe), .ale_o(ale_o), .rd_n(rd_n), .wr_n(wr_n), .hwr_n(hwr_n),
    .rw_o(rw_o), .cs_n(cs_n), .bus_drive(bus_drive)
  );

endmodule

// File: rtl/muxbus_chk.sv
module muxbus_chk #(
  parameter int N_CS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ale_o,
  input logic            rd_n,
  input logic            wr_n,
  input logic            hwr_n,
  input logic            rw_o,
  input logic            ad_oe,
  input logic [N_CS-1:0] cs_n,
  input logic            bus_drive,
  input logic            busak_n,
  input logic            wait_n,
  input logic            int_acc,
  input logic            rsp_valid
);

  // R2
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (rd_n && wr_n && hwr_n && ad_oe));

  // R3
  rd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (rw_o && !ad_oe && wr_n && hwr_n));

  // R4
  wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !hwr_n) |-> (!rw_o && ad_oe && rd_n));

  // R5
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R7
  int_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_acc |=> (!ale_o && (cs_n == '1) && rd_n && wr_n && hwr_n && rsp_valid));

  // R8
  rel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busak_n |-> (!bus_drive && !ad_oe && rd_n && wr_n && hwr_n && !ale_o));

  // R9
  grant_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busak_n) |-> $past(wait_n));

  // R10
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busak_n) |-> $past(rd_n && wr_n && hwr_n && !ale_o));

  // R11
  ret_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busak_n) |-> !bus_drive);

endmodule

bind muxbus_ctrl muxbus_chk #(.N_CS(N_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale_o(ale_o), .rd_n(rd_n), .wr_n(wr_n),
  .hwr_n(hwr_n), .rw_o(rw_o), .ad_oe(ad_oe), .cs_n(cs_n),
  .bus_drive(bus_drive), .busak_n(busak_n), .wait_n(wait_n),
  .int_acc(int_acc), .rsp_valid(rsp_valid)
);

// File: tb/sim_muxbus_ctrl.sv
module sim_muxbus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [95:0] cs_base;
  logic [95:0] cs_mask;
  logic [3:0]  cs_wait_en;
  logic [23:0] addr_o;
  logic [15:0] ad_o;
  logic [15:0] ad_i = '0;
  logic        ad_oe, ale_o, rd_n, wr_n, hwr_n, rw_o, bus_drive, busak_n;
  logic [3:0]  cs_n;
  logic        wait_n = 1'b1;
  logic        busrq_n = 1'b1;

  logic [23:0] cb [4];
  logic [23:0] cm [4];
  logic [3:0]  cw;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  assign cs_base    = {cb[3], cb[2], cb[1], cb[0]};
  assign cs_mask    = {cm[3], cm[2], cm[1], cm[0]};
  assign cs_wait_en = cw;

  muxbus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cs_base(cs_base), .cs_mask(cs_mask), .cs_wait_en(cs_wait_en),
    .addr_o(addr_o), .ad_o(ad_o), .ad_i(ad_i), .ad_oe(ad_oe), .ale_o(ale_o),
    .rd_n(rd_n), .wr_n(wr_n), .hwr_n(hwr_n), .rw_o(rw_o), .cs_n(cs_n),
    .bus_drive(bus_drive), .wait_n(wait_n), .busrq_n(busrq_n),
    .busak_n(busak_n)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // first matching window in ascending order, active-low
  function automatic logic [3:0] exp_cs(input logic [23:0] a);
    logic [3:0] r = 4'hF;
    bit found = 0;
    for (int i = 0; i < 4; i++) begin
      if (!found && ((a & ~cm[i]) == (cb[i] & ~cm[i]))) begin
        r[i]  = 1'b0;
        found = 1;
      end
    end
    return r;
  endfunction

  function automatic bit exp_wen(input logic [23:0] a);
    logic [3:0] c = exp_cs(a);
    return (c != 4'hF) && ((~c & cw) != 4'b0);
  endfunction

  task automatic access(input logic [23:0] a, input bit w, input logic [1:0] be,
                        input logic [15:0] wd, input logic [15:0] rv,
                        input int nwait, input bit internal);
    int ale_cnt = 0, rd_cnt = 0, wr_cnt = 0, hwr_cnt = 0;
    int first_stb = -1, rsp_idx = -1, ale_last = -1;
    bit ad_ok = 1, wd_ok = 1, rw_ok = 1, cs_ok = 1, stb;
    logic [15:0] got = '0;
    logic [3:0]  ecs = internal ? 4'hF : exp_cs(a);
    bit wen = !internal && exp_wen(a);
    int sl = w ? 3 : 4;
    int slen = wen ? sl + 2 + 2 * nwait : sl;
    string tag = internal ? "R7" : (wen ? "R6" : (w ? "R4" : "R3"));
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_write = w; req_be = be;
    req_wdata = wd; ad_i = rv;
    for (int i = 0; i < 200 && rsp_idx < 0; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      if (ale_o) begin
        ale_cnt++; ale_last = i;
        if (ad_o != a[15:0] || !ad_oe || addr_o != a) ad_ok = 0;
      end
      stb = !rd_n || !wr_n || !hwr_n;
      if (stb) begin
        if (first_stb < 0) begin
          first_stb = i;
          if (nwait > 0) wait_n = 1'b0;
        end
        if (!rd_n) rd_cnt++;
        if (!wr_n) wr_cnt++;
        if (!hwr_n) hwr_cnt++;
        if (w && ad_o != wd) wd_ok = 0;
        if (rw_o != !w) rw_ok = 0;
        if (i - first_stb == sl + 2 * nwait) wait_n = 1'b1;
      end
      if (cs_n != ecs) cs_ok = 0;
      if (rsp_valid) begin rsp_idx = i; got = rsp_rdata; end
    end
    wait_n = 1'b1;
    if (internal) begin
      // R7: silent internal access
      chk(ale_cnt == 0 && first_stb < 0, "R7 no strobes", ale_cnt, 0);
      chk(rsp_idx == 0, "R7 rsp timing", rsp_idx, 0);
      if (!w) chk(got == 16'h0, "R7 rdata", got, 0);
    end else begin
      chk(ale_cnt == 2 && ale_last == 1 && ad_ok, "R2 latch phases", ale_cnt, 2);
      chk(first_stb == 3, "R2 strobe start", first_stb, 3);
      if (w) begin
        chk(wr_cnt == (be[0] ? slen : 0), {tag, " wr_n length"}, wr_cnt, be[0] ? slen : 0);
        chk(hwr_cnt == (be[1] ? slen : 0), {tag, " hwr_n length"}, hwr_cnt, be[1] ? slen : 0);
        chk(wd_ok && rw_ok && rd_cnt == 0, "R4 write data/rw", {wd_ok, rw_ok}, 3);
      end else begin
        chk(rd_cnt == slen, {tag, " rd_n length"}, rd_cnt, slen);
        chk(got == rv && rw_ok, "R3 read data", got, rv);
      end
      chk(rsp_idx == 3 + slen, {tag, " rsp timing"}, rsp_idx, 3 + slen);
    end
    chk(cs_ok, "R5 chip select", cs_n, ecs);
  endtask

  task automatic t_reset;
    chk(!ale_o && rd_n && wr_n && hwr_n && rw_o, "R1 strobes idle",
        {ale_o, rd_n, wr_n, hwr_n, rw_o}, 5'b01111);
    chk(cs_n == 4'hF && busak_n && bus_drive && !ad_oe, "R1 cs/bus idle",
        {cs_n, busak_n, bus_drive, ad_oe}, 7'b1111110);
  endtask

  task automatic t_release;
    @(negedge clk); busrq_n = 1'b0;
    @(negedge clk);
    chk(!busak_n && !bus_drive && !ad_oe, "R8 grant floats",
        {busak_n, bus_drive, ad_oe}, 0);
    req_valid = 1'b1; req_addr = 24'h012000; req_write = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!busak_n && !ale_o && !req_ready, "R8 held released",
          {busak_n, ale_o, req_ready}, 0);
    end
    req_valid = 1'b0;
    busrq_n = 1'b1;
    @(negedge clk);
    chk(busak_n && !bus_drive, "R11 ack first", {busak_n, bus_drive}, 2'b10);
    @(negedge clk);
    chk(bus_drive == 1'b1, "R11 drive back", bus_drive, 1);
  endtask

  task automatic t_wait_block;
    @(negedge clk); wait_n = 1'b0; busrq_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(busak_n == 1'b1, "R9 no grant under wait", busak_n, 1);
    end
    wait_n = 1'b1;
    @(negedge clk);
    chk(busak_n == 1'b0, "R9 grant after wait", busak_n, 0);
    busrq_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_mid_access;
    int first = -1;
    bit ok = 1, seen = 0, granted = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 24'h030010; req_write = 1'b0; ad_i = 16'h5A5A;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      if (!busak_n) ok = 0;
      if (!rd_n && first < 0) begin first = i; wait_n = 1'b0; busrq_n = 1'b0; end
      if (first >= 0 && i - first == 4 + 4) wait_n = 1'b1;
      if (rsp_valid) seen = 1;
    end
    chk(ok && seen, "R10 no grant mid access", {ok, seen}, 3);
    for (int i = 0; i < 3 && !granted; i++) begin
      @(negedge clk);
      if (!busak_n) granted = 1;
    end
    chk(granted, "R10 grant after access", granted, 1);
    busrq_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_collide;
    bit ale_seen = 0, rsp_seen = 0, early = 0;
    @(negedge clk);
    busrq_n = 1'b0; req_valid = 1'b1; req_addr = 24'h013000; req_write = 1'b0;
    ad_i = 16'hC0DE;
    @(negedge clk);
    chk(!busak_n && !ale_o, "R12 release wins", {busak_n, ale_o}, 0);
    @(negedge clk);
    busrq_n = 1'b1;
    for (int i = 0; i < 10 && !ale_seen; i++) begin
      @(negedge clk);
      if (ale_o) begin
        ale_seen = 1; req_valid = 1'b0;
        if (!bus_drive) early = 1;
      end
    end
    chk(ale_seen && !early, "R12 request runs after return", {ale_seen, early}, 2);
    for (int i = 0; i < 30 && !rsp_seen; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        rsp_seen = 1;
        chk(rsp_rdata == 16'hC0DE, "R12 read data", rsp_rdata, 16'hC0DE);
      end
    end
    chk(rsp_seen, "R12 completion", rsp_seen, 1);
  endtask

  initial begin
    cb[0] = 24'h010000; cm[0] = 24'h00FFFF;
    cb[1] = 24'h020000; cm[1] = 24'h01FFFF;
    cb[2] = 24'h000000; cm[2] = 24'h0FFFFF;
    cb[3] = 24'h800000; cm[3] = 24'h0FFFFF;
    cw    = 4'b1010;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    access(24'h012345, 0, 2'b11, 16'h0000, 16'hBEEF, 0, 0);
    access(24'h01ABCE, 1, 2'b11, 16'h1234, 16'h0000, 0, 0);
    access(24'h01ABCE, 1, 2'b01, 16'h00A5, 16'h0000, 0, 0);
    access(24'h01ABCF, 1, 2'b10, 16'h7E00, 16'h0000, 0, 0);
    access(24'h051234, 0, 2'b11, 16'h0000, 16'h4321, 0, 0);
    access(24'h400000, 0, 2'b11, 16'h0000, 16'h9999, 0, 0);
    access(24'h028000, 0, 2'b11, 16'h0000, 16'h1111, 0, 0);
    access(24'h03F000, 1, 2'b11, 16'hCAFE, 16'h0000, 2, 0);
    access(24'h812340, 0, 2'b11, 16'h0000, 16'h7777, 3, 0);
    access(24'h000800, 0, 2'b11, 16'h0000, 16'hFFFF, 0, 1);
    access(24'h002000, 1, 2'b11, 16'h3333, 16'h0000, 0, 1);
    access(24'hFC1000, 0, 2'b11, 16'h0000, 16'hABCD, 0, 1);
    t_release();
    t_wait_block();
    t_mid_access();
    t_collide();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule